// File: doc/BRIEF.md
# Configuration Window Bridge

This block sits on a host's 16-bit I/O port bus and turns the classic two-port indirect configuration scheme into single configuration transactions. A 32-bit selector register at port 0xCF8 names the target: an enable flag, a bus number, a device/function number and a 12-bit register byte address, of which only the dword index is kept. Accesses to the four data ports 0xCFC to 0xCFF then become one configuration read or write carrying those fields, with byte enables taken from the size and port offset of the I/O access.

The I/O bus is lane-aligned: byte n of the 32-bit data path always carries byte lane n, so a byte access at port 0xCFD moves data on bits 15:8. Every I/O access is held by the master until the block raises `io_ready` for one cycle. Only one transaction is outstanding at a time. A configuration request that gets no acknowledge in time is closed by the block itself as a master abort.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset `io_ready` and `cfg_req` are low and the selector register reads 0x00000000.
- R2: A dword write (size code 2) to port 0xCF8 stores bits 31 and 27:2 of the write data. Bits 30:28 and 1:0 read as zero, so a write of 0x80000000 reads back as exactly 0x80000000 and a write of 0xFFFFFFFF reads back as 0x8FFFFFFC.
- R3: Byte (size code 0) or word (size code 1) writes to ports 0xCF8 to 0xCFB complete normally and leave the selector register unchanged.
- R4: A read of ports 0xCF8 to 0xCFB returns the selector register on the active byte lanes and zero on the other lanes.
- R5: With bit 31 of the selector set, a data-port access issues exactly one configuration request with `cfg_bus` = selector bits 23:16, `cfg_devfn` = bits 15:8, `cfg_reg` = {bits 27:24, bits 7:2}, and `cfg_we` equal to the I/O direction.
- R6: Byte enables: a byte access at port 0xCFC+n sets only bit n; a word access sets 4'b0011 when port bit 1 is 0 and 4'b1100 when it is 1; a dword access sets 4'b1111. `cfg_wdata` equals the I/O write data unshifted.
- R7: An acknowledged read returns `cfg_rdata` on the active lanes and zero on the others.
- R8: With bit 31 of the selector clear, a data-port access issues no request, and a read returns 0xFF on each active lane and zero on the others.
- R9: A request that has seen no acknowledge by its 16th cycle is dropped: a read then returns 0xFF on each active lane, a write is discarded. An acknowledge in the 16th cycle still completes normally.
- R10: `cfg_req` stays high, with fields unchanged, until acknowledge or timeout; `io_ready` is a one-cycle pulse per access and is never high together with `cfg_req`.
- R11: An access to any other port completes with read data zero and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | I/O access present, held until `io_ready` |
| io_we | input | 1 | 1 = port write, 0 = port read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 = byte, 1 = word, 2 = dword |
| io_wdata | input | 32 | Lane-aligned write data |
| io_rdata | output | 32 | Lane-aligned read data, valid with `io_ready` |
| io_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 10 | Dword index of the register |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Request accepted and finished |
| cfg_rdata | input | 32 | Read data, valid with `cfg_ack` |

## Verification
Directed accesses cover selector save, probe and restore, sub-dword writes to the selector that must leave it intact, and a disabled window, which tells the abort path apart from a real request. Acknowledge delays of 16 and never separate the last legal cycle from the timeout. Random selector values, sizes, port offsets and directions with random delays then check the field split and lane mapping, since any swapped or shifted field changes the logged request or the masked read data.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } io_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } txn_state_e;

  // Expand per-lane enables to a bit mask over the data path.
  function automatic logic [DW-1:0] lanes_to_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_window_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  output logic [LANES-1:0] be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE:  be[g] = (offset == g[1:0]);
        SZ_WORD:  be[g] = (offset[1] == g[1]);
        default:  be[g] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] KEEP = 32'h8FFF_FFFC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata & KEEP;
  end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_window_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int REGW    = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic             idle,
  input  logic             start_cfg,
  input  logic             start_local,
  input  logic [DW-1:0]    local_rdata,
  input  logic             req_we,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [REGW-1:0]  req_reg,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [REGW-1:0]  cfg_reg,
  output logic [LANES-1:0] cfg_be,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic [DW-1:0]    cfg_rdata,
  output logic [DW-1:0]    io_rdata,
  output logic             io_ready
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  txn_state_e    state;
  logic [CW-1:0] wait_cnt;
  logic [DW-1:0] lane_mask;

  assign idle      = (state == ST_IDLE);
  assign lane_mask = lanes_to_mask(cfg_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_bus   <= '0;
      cfg_devfn <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      wait_cnt  <= '0;
      io_rdata  <= '0;
      io_ready  <= 1'b0;
    end else begin
      io_ready <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_cfg) begin
            cfg_req   <= 1'b1;
            cfg_we    <= req_we;
            cfg_bus   <= req_bus;
            cfg_devfn <= req_devfn;
            cfg_reg   <= req_reg;
            cfg_be    <= req_be;
            cfg_wdata <= req_wdata;
            wait_cnt  <= '0;
            state     <= ST_WAIT;
          end else if (start_local) begin
            io_rdata <= req_we ? '0 : (local_rdata & lanes_to_mask(req_be));
            io_ready <= 1'b1;
            state    <= ST_RESP;
          end
        end
        ST_WAIT: begin
          // Acknowledge wins over timeout in the last allowed cycle.
          if (cfg_ack) begin
            io_rdata <= cfg_we ? '0 : (cfg_rdata & lane_mask);
            cfg_req  <= 1'b0;
            io_ready <= 1'b1;
            state    <= ST_RESP;
          end else if (wait_cnt == LAST) begin
            io_rdata <= cfg_we ? '0 : lane_mask;
            cfg_req  <= 1'b0;
            io_ready <= 1'b1;
            state    <= ST_RESP;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfg_window_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC,
  parameter int          TIMEOUT   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_valid,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_ready,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [9:0]       cfg_reg,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata
);
  localparam int REGW = 10;

  logic [DW-1:0]    areg_q;
  logic [LANES-1:0] acc_be;
  logic             idle, accept, hit_sel, hit_win, sel_wr, start_cfg, start_local;
  logic [DW-1:0]    local_rdata;

  assign hit_sel     = (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  assign hit_win     = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
  assign accept      = io_valid && idle;
  assign sel_wr      = accept && hit_sel && io_we && (io_size == SZ_DWORD);
  assign start_cfg   = accept && hit_win && areg_q[31];
  assign start_local = accept && !start_cfg;
  assign local_rdata = hit_sel ? areg_q : (hit_win ? '1 : '0);

  cfg_lane_map u_lanes (
    .size   (io_size),
    .offset (io_addr[1:0]),
    .be     (acc_be)
  );

  cfg_addr_reg #(.W(DW)) u_areg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (sel_wr),
    .wdata (io_wdata),
    .q     (areg_q)
  );

  cfg_txn_ctrl #(.TIMEOUT(TIMEOUT), .REGW(REGW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .idle        (idle),
    .start_cfg   (start_cfg),
    .start_local (start_local),
    .local_rdata (local_rdata),
    .req_we      (io_we),
    .req_bus     (areg_q[23:16]),
    .req_devfn   (areg_q[15:8]),
    .req_reg     ({areg_q[27:24], areg_q[7:2]}),
    .req_be      (acc_be),
    .req_wdata   (io_wdata),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_bus     (cfg_bus),
    .cfg_devfn   (cfg_devfn),
    .cfg_reg     (cfg_reg),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_ack     (cfg_ack),
    .cfg_rdata   (cfg_rdata),
    .io_rdata    (io_rdata),
    .io_ready    (io_ready)
  );
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter int          TIMEOUT   = 16,
  parameter logic [15:0] ADDR_PORT = 16'hCF8
) (
  input logic        clk,
  input logic        rst,
  input logic        io_ready,
  input logic        io_we,
  input logic [15:0] io_addr,
  input logic [31:0] io_rdata,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [3:0]  cfg_be,
  input logic        enable
);
  localparam int CW = $clog2(TIMEOUT) + 2;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (cfg_req) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!io_ready && !cfg_req));

  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (io_ready && !io_we && io_addr[15:2] == ADDR_PORT[15:2])
      |-> (io_rdata[30:28] == 3'b0 && io_rdata[1:0] == 2'b0));

  assert_be_shape_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                 $countones(cfg_be) == 4));

  assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> enable);

  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (hi_cnt < CW'(TIMEOUT)));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack && hi_cnt < CW'(TIMEOUT - 1)) |=> cfg_req);

  assert_be_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && $past(cfg_req)) |-> $stable(cfg_be));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    io_ready |=> !io_ready);

  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (rst)
    io_ready |-> !cfg_req);
endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(
  .TIMEOUT   (TIMEOUT),
  .ADDR_PORT (ADDR_PORT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_ready (io_ready),
  .io_we    (io_we),
  .io_addr  (io_addr),
  .io_rdata (io_rdata),
  .cfg_req  (cfg_req),
  .cfg_ack  (cfg_ack),
  .cfg_be   (cfg_be),
  .enable   (areg_q[31])
);

// File: tb/cfg_window_bridge_bench.sv
module cfg_window_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_ready;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [9:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int tests = 0, fails = 0;

  always #5ns clk = ~clk;

  cfg_window_bridge u_cfg_window_bridge (.*);

  // Device model: acknowledges after ack_delay cycles of cfg_req (0 = never).
  int          ack_delay = 1;
  int          nreq = 0, hi = 0;
  bit          prev_hi = 0;
  logic        l_we;
  logic [7:0]  l_bus, l_devfn;
  logic [9:0]  l_reg;
  logic [3:0]  l_be;
  logic [31:0] l_wdata;

  function automatic logic [31:0] mdata(input logic [7:0] b, input logic [7:0] d,
                                        input logic [9:0] r);
    return {r, 6'h2A, d, b};
  endfunction

  function automatic logic [3:0] be_of(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  always @(negedge clk) begin
    if (cfg_req) begin
      if (!prev_hi) begin
        nreq++; hi = 0;
        l_we = cfg_we; l_bus = cfg_bus; l_devfn = cfg_devfn;
        l_reg = cfg_reg; l_be = cfg_be; l_wdata = cfg_wdata;
      end
      hi++;
      cfg_rdata = mdata(cfg_bus, cfg_devfn, cfg_reg);
      cfg_ack   = (ack_delay != 0) && (hi == ack_delay);
      prev_hi   = 1'b1;
    end else begin
      cfg_ack = 1'b0;
      prev_hi = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
    int n = 0;
    io_valid = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    do begin
      @(negedge clk);
      n++;
    end while (!io_ready && n < 200);
    if (!io_ready) check(1'b0, "R10 access hung", 32'(n), 32'd0);
    rd = io_rdata;
    io_valid = 1'b0;
  endtask

  initial begin
    #2ms;
    fails++; tests++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, sel, wd;
    int n0;
    void'($urandom(32'h00C0_F1A5));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(!io_ready && !cfg_req, "R1 idle outputs", {30'b0, io_ready, cfg_req}, 32'd0);
    xfer(1'b0, 16'hCF8, 2'd2, '0, rd);
    check(rd == 32'h0, "R1 selector after reset", rd, 32'h0);

    // Save/probe/restore style access.
    xfer(1'b1, 16'hCF8, 2'd2, 32'h8000_0000, rd);
    xfer(1'b0, 16'hCF8, 2'd2, '0, rd);
    check(rd == 32'h8000_0000, "R2 probe readback", rd, 32'h8000_0000);
    xfer(1'b1, 16'hCF8, 2'd2, 32'hFFFF_FFFF, rd);
    xfer(1'b0, 16'hCF8, 2'd2, '0, rd);
    check(rd == 32'h8FFF_FFFC, "R2 reserved bits", rd, 32'h8FFF_FFFC);

    // Sub-dword writes to the selector are ignored.
    xfer(1'b1, 16'hCFA, 2'd0, 32'h0011_0000, rd);
    xfer(1'b1, 16'hCF8, 2'd1, 32'h0000_1234, rd);
    xfer(1'b0, 16'hCF8, 2'd2, '0, rd);
    check(rd == 32'h8FFF_FFFC, "R3 partial writes ignored", rd, 32'h8FFF_FFFC);
    xfer(1'b0, 16'hCFB, 2'd0, '0, rd);
    check(rd == 32'h8F00_0000, "R4 byte readback lane 3", rd, 32'h8F00_0000);

    // Window disabled.
    xfer(1'b1, 16'hCF8, 2'd2, 32'h0012_3400, rd);
    n0 = nreq;
    xfer(1'b0, 16'hCFC, 2'd2, '0, rd);
    check(rd == 32'hFFFF_FFFF && nreq == n0, "R8 disabled dword", rd, 32'hFFFF_FFFF);
    xfer(1'b0, 16'hCFE, 2'd0, '0, rd);
    check(rd == 32'h00FF_0000 && nreq == n0, "R8 disabled byte", rd, 32'h00FF_0000);

    // Enabled: field split, lanes, data.
    xfer(1'b1, 16'hCF8, 2'd2, 32'h8A12_34BC, rd);
    ack_delay = 3; n0 = nreq;
    xfer(1'b0, 16'hCFD, 2'd0, '0, rd);
    check(nreq == n0 + 1, "R5 one request", 32'(nreq - n0), 32'd1);
    check({l_bus, l_devfn} == 16'h1234 && !l_we, "R5 bus/devfn", {16'h0, l_bus, l_devfn}, 32'h1234);
    check(l_reg == 10'h2AF, "R5 register index", 32'(l_reg), 32'h2AF);
    check(l_be == 4'b0010, "R6 byte lane 1", 32'(l_be), 32'h2);
    check(rd == (mdata(8'h12, 8'h34, 10'h2AF) & 32'h0000_FF00), "R7 read lane data",
          rd, mdata(8'h12, 8'h34, 10'h2AF) & 32'h0000_FF00);
    xfer(1'b1, 16'hCFE, 2'd1, 32'hBEEF_0000, rd);
    check(l_be == 4'b1100 && l_we, "R6 upper word lanes", 32'(l_be), 32'hC);
    check(l_wdata == 32'hBEEF_0000, "R6 write data", l_wdata, 32'hBEEF_0000);

    // Timeout boundary.
    ack_delay = 16;
    xfer(1'b0, 16'hCFC, 2'd2, '0, rd);
    check(rd == mdata(8'h12, 8'h34, 10'h2AF), "R9 ack in last cycle", rd,
          mdata(8'h12, 8'h34, 10'h2AF));
    ack_delay = 0;
    xfer(1'b0, 16'hCFC, 2'd1, '0, rd);
    check(rd == 32'h0000_FFFF, "R9 abort read ones", rd, 32'h0000_FFFF);
    check(hi == 16, "R9 request length", 32'(hi), 32'd16);
    n0 = nreq;
    xfer(1'b1, 16'hCFC, 2'd2, 32'h1234_5678, rd);
    check(nreq == n0 + 1 && rd == 32'h0, "R9 abort write completes", rd, 32'h0);

    // Unrelated port.
    ack_delay = 1; n0 = nreq;
    xfer(1'b0, 16'h0080, 2'd2, '0, rd);
    check(rd == 32'h0 && nreq == n0, "R11 other port", rd, 32'h0);

    // Random mix.
    for (int it = 0; it < 150; it++) begin
      logic [1:0] sz, off;
      logic we;
      logic [3:0] be;
      sel = $urandom;
      if ($urandom % 4 == 0) sel[31] = 1'b0; else sel[31] = 1'b1;
      xfer(1'b1, 16'hCF8, 2'd2, sel, rd);
      sel = sel & 32'h8FFF_FFFC;
      sz  = 2'($urandom % 3);
      off = 2'($urandom % 4);
      we  = 1'($urandom % 2);
      wd  = $urandom;
      ack_delay = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 5);
      be  = be_of(sz, off);
      n0  = nreq;
      xfer(we, 16'hCFC + 16'(off), sz, wd, rd);
      if (sel[31]) begin
        check(nreq == n0 + 1 && l_bus == sel[23:16] && l_devfn == sel[15:8] &&
              l_reg == {sel[27:24], sel[7:2]} && l_we == we,
              "R5 random fields", {12'h0, l_reg, l_devfn, 2'b0}, {12'h0, sel[27:24], sel[7:2], sel[15:8], 2'b0});
        check(l_be == be && (!we || l_wdata == wd), "R6 random lanes", 32'(l_be), 32'(be));
        check(rd == (we ? 32'h0 : (ack_delay != 0 ? mdata(sel[23:16], sel[15:8],
              {sel[27:24], sel[7:2]}) & mask_of(be) : mask_of(be))),
              "R7 random read data", rd,
              we ? 32'h0 : (ack_delay != 0 ? mdata(sel[23:16], sel[15:8],
              {sel[27:24], sel[7:2]}) & mask_of(be) : mask_of(be)));
      end else begin
        check(nreq == n0 && rd == (we ? 32'h0 : mask_of(be)), "R8 random disabled",
              rd, we ? 32'h0 : mask_of(be));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule